// File: doc/BRIEF.md
# Single-Wire Open-Drain Bus Master

This block is the master for a single-wire, open-drain serial bus. It owns eight independent bus lines and works on one at a time, chosen when a command starts. The master only ever pulls the selected line low or lets it go; the high level comes from an external pull-up. The bench and the surrounding logic model each line as an output-enable (`busOe`, 1 = pull low) plus the sampled line level (`busIn`).

Two commands exist. A reset command holds the line low for a fixed time, releases it, and samples once for a slave's low presence answer. A byte command moves 1 to 255 bytes as time slots. Each slot begins with a low pulse from the master. Data goes least-significant bit first. Write bytes are taken from `txData` through a one-cycle acknowledge. Read bytes are handed out on `rxData` with a one-cycle valid strobe. The slot low time, the read sample point, the slot length and the recovery gap come from run-time configuration inputs, counted in clock cycles. While idle, a low on the selected line is taken as the presence pulse of a newly attached slave.

Top module: `owBusMaster`

## Requirements
- R1: After reset, `busy`, `done`, `presence`, `rxValid`, `txAck` are 0 and no line is pulled low.
- R2: Only the line whose index was on `busSel` when the command was accepted is ever pulled low. Bit i of `busOe` pulls line i. All lines are released while not busy.
- R3: A reset command pulls the line low for RESET_LOW_TICKS cycles, starting the cycle after acceptance. It then releases the line and stays busy for RESET_HIGH_TICKS more cycles.
- R4: A reset command clears `presence` at acceptance. At tick RESET_LOW_TICKS+PRESENCE_DELAY of the command, it sets `presence` to 1 if the line reads low and to 0 otherwise. The value holds until the next reset command, except as in R5.
- R5: While idle, a low level on the line currently indexed by `busSel` sets `presence`. Lows on other lines have no effect.
- R6: A byte command with `byteCount` 0 is ignored: `busy` stays 0 and no `done` follows. Counts 1 to 255 move that many bytes.
- R7: A write slot pulls the line low for `cfgLowTicks` cycles for a 1 bit, or `cfgSlotTicks` cycles for a 0 bit. The line is then released until the slot's `cfgSlotTicks + cfgRecoverTicks` cycles are over. Bits go out LSB first.
- R8: A read slot pulls the line low for `cfgLowTicks` cycles and samples it at tick `cfgSampleTicks` of the slot. Bits fill `rxData` LSB first. `rxValid` pulses for one cycle after each byte's last slot.
- R9: `txData` is captured when a write command is accepted and again at each byte boundary. `txAck` pulses once, the cycle after each capture.
- R10: `busy` is high from the cycle after acceptance through the last tick of the command. `done` is a one-cycle pulse in the cycle after `busy` falls.
- R11: A start request while busy is ignored. It changes neither the active line nor the command, and it adds no extra `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startReq | input | 1 | One-cycle command start |
| cmdReset | input | 1 | 1 = reset/presence command, 0 = byte command |
| cmdRead | input | 1 | Byte command direction, 1 = read |
| busSel | input | SEL_W | Line index for the command and for idle presence watch |
| byteCount | input | CNT_W | Bytes to move, 1..255 |
| txData | input | DATA_W | Next write byte |
| txAck | output | 1 | Write byte taken (one cycle) |
| rxData | output | DATA_W | Last received byte |
| rxValid | output | 1 | `rxData` holds a new byte (one cycle) |
| cfgLowTicks | input | CFG_W | Slot low time |
| cfgSampleTicks | input | CFG_W | Read sample tick within a slot |
| cfgSlotTicks | input | CFG_W | Slot length before recovery |
| cfgRecoverTicks | input | CFG_W | Recovery gap after each slot |
| busIn | input | NUM_BUS | Sampled line levels |
| busOe | output | NUM_BUS | Pull-low enables |
| busy | output | 1 | Command in progress |
| done | output | 1 | Command finished (one cycle) |
| presence | output | 1 | Slave presence seen |

## Verification
The assertions check on every cycle that at most one line is driven and that all lines are released while idle. They also check that no command is latched while busy, that `done` only follows a falling `busy`, that `txAck` never lasts two cycles, and that a byte command never runs with a zero count. Only the bench scenarios can show the rest. These are the bit order and slot shapes seen on the wire, the exact reset and presence timing, and the data returned from a responding slave. They also cover hot-plug presence on the watched line versus other lines, and the zero-count and start-while-busy cases.

// File: rtl/owPkg.sv
package owPkg;
  typedef enum logic [1:0] {
    OW_IDLE  = 2'd0,
    OW_RESET = 2'd1,
    OW_SLOT  = 2'd2
  } owState_e;

  typedef struct packed {
    logic loadCfg;
    logic loadByte;
    logic shiftTx;
    logic sampleBit;
    logic emitByte;
    logic clearPres;
    logic samplePres;
    logic setPres;
    logic lowPhase;
    logic zeroWindow;
    logic finish;
  } owStrobes_t;
endpackage

// File: rtl/owCtl.sv
module owCtl
  import owPkg::*;
#(
  parameter int NUM_BUS          = 8,
  parameter int DATA_W           = 8,
  parameter int CNT_W            = 8,
  parameter int CFG_W            = 8,
  parameter int RESET_LOW_TICKS  = 96,
  parameter int RESET_HIGH_TICKS = 96,
  parameter int PRESENCE_DELAY   = 14,
  localparam int SEL_W = $clog2(NUM_BUS),
  localparam int BIT_W = $clog2(DATA_W)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               startReq,
  input  logic               cmdReset,
  input  logic               cmdRead,
  input  logic [SEL_W-1:0]   busSel,
  input  logic [CNT_W-1:0]   byteCount,
  input  logic [NUM_BUS-1:0] busIn,
  input  logic [CFG_W-1:0]   cfgLowTicks,
  input  logic [CFG_W-1:0]   cfgSampleTicks,
  input  logic [CFG_W-1:0]   cfgSlotTicks,
  input  logic [CFG_W-1:0]   cfgRecoverTicks,
  output logic               busy,
  output owStrobes_t         strb
);
  localparam int RST_TOTAL = RESET_LOW_TICKS + RESET_HIGH_TICKS;
  localparam int RST_W     = $clog2(RST_TOTAL + 1);
  localparam int T_W       = (RST_W > CFG_W + 2) ? RST_W : CFG_W + 2;
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_W - 1);

  owState_e         state;
  logic [T_W-1:0]   tick;
  logic [BIT_W-1:0] bitIdx;
  logic [CNT_W-1:0] bytesLeft;
  logic             readMode;
  logic [T_W-1:0]   slotLast;
  logic             slotEnd;
  logic             rstEnd;

  assign slotLast = T_W'(cfgSlotTicks) + T_W'(cfgRecoverTicks) - T_W'(1);
  assign slotEnd  = (tick == slotLast);
  assign rstEnd   = (tick == T_W'(RST_TOTAL - 1));
  assign busy     = (state != OW_IDLE);

  always_comb begin
    strb = '0;
    unique case (state)
      OW_IDLE: begin
        strb.setPres = ~busIn[busSel];
        if (startReq) begin
          if (cmdReset) begin
            strb.loadCfg   = 1'b1;
            strb.clearPres = 1'b1;
          end else if (byteCount != '0) begin
            strb.loadCfg  = 1'b1;
            strb.loadByte = ~cmdRead;
          end
        end
      end
      OW_RESET: begin
        strb.lowPhase   = (tick < T_W'(RESET_LOW_TICKS));
        strb.samplePres = (tick == T_W'(RESET_LOW_TICKS + PRESENCE_DELAY));
        strb.finish     = rstEnd;
      end
      OW_SLOT: begin
        strb.lowPhase   = (tick < T_W'(cfgLowTicks));
        strb.zeroWindow = ~readMode && (tick < T_W'(cfgSlotTicks));
        strb.sampleBit  = readMode && (tick == T_W'(cfgSampleTicks));
        if (slotEnd) begin
          if (bitIdx == LAST_BIT) begin
            strb.emitByte = readMode;
            if (bytesLeft == CNT_W'(1)) strb.finish = 1'b1;
            else                        strb.loadByte = ~readMode;
          end else begin
            strb.shiftTx = ~readMode;
          end
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= OW_IDLE;
      tick      <= '0;
      bitIdx    <= '0;
      bytesLeft <= '0;
      readMode  <= 1'b0;
    end else begin
      unique case (state)
        OW_IDLE: begin
          tick   <= '0;
          bitIdx <= '0;
          if (startReq && cmdReset) begin
            state <= OW_RESET;
          end else if (startReq && byteCount != '0) begin
            state     <= OW_SLOT;
            bytesLeft <= byteCount;
            readMode  <= cmdRead;
          end
        end
        OW_RESET: begin
          if (rstEnd) state <= OW_IDLE;
          else        tick  <= tick + T_W'(1);
        end
        OW_SLOT: begin
          if (slotEnd) begin
            tick   <= '0;
            bitIdx <= bitIdx + BIT_W'(1);
            if (bitIdx == LAST_BIT) begin
              if (bytesLeft == CNT_W'(1)) state <= OW_IDLE;
              else                        bytesLeft <= bytesLeft - CNT_W'(1);
            end
          end else begin
            tick <= tick + T_W'(1);
          end
        end
        default: state <= OW_IDLE;
      endcase
    end
  end

  // R6: a byte command never runs with nothing left to move
  assert_count_nonzero_R6: assert property (@(posedge clk) disable iff (!rstN)
    (state == OW_SLOT) |-> (bytesLeft != '0));
endmodule

// File: rtl/owDp.sv
module owDp
  import owPkg::*;
#(
  parameter int NUM_BUS = 8,
  parameter int DATA_W  = 8,
  localparam int SEL_W = $clog2(NUM_BUS)
) (
  input  logic               clk,
  input  logic               rstN,
  input  owStrobes_t         strb,
  input  logic [SEL_W-1:0]   busSel,
  input  logic [DATA_W-1:0]  txData,
  input  logic [NUM_BUS-1:0] busIn,
  output logic [NUM_BUS-1:0] busOe,
  output logic               presence,
  output logic [DATA_W-1:0]  rxData,
  output logic               rxValid,
  output logic               txAck,
  output logic               done
);
  logic [SEL_W-1:0]  selReg;
  logic [DATA_W-1:0] txShift;
  logic [DATA_W-1:0] rxShift;
  logic              driveLow;

  assign driveLow = strb.lowPhase | (strb.zeroWindow & ~txShift[0]);
  assign rxData   = rxShift;

  for (genvar i = 0; i < NUM_BUS; i++) begin : gOe
    assign busOe[i] = driveLow && (selReg == SEL_W'(i));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      selReg   <= '0;
      txShift  <= '0;
      rxShift  <= '0;
      presence <= 1'b0;
      rxValid  <= 1'b0;
      txAck    <= 1'b0;
      done     <= 1'b0;
    end else begin
      if (strb.loadCfg) selReg <= busSel;
      if (strb.loadByte)     txShift <= txData;
      else if (strb.shiftTx) txShift <= txShift >> 1;
      if (strb.sampleBit) rxShift <= {busIn[selReg], rxShift[DATA_W-1:1]};
      if (strb.clearPres)       presence <= 1'b0;
      else if (strb.samplePres) presence <= ~busIn[selReg];
      else if (strb.setPres)    presence <= 1'b1;
      rxValid <= strb.emitByte;
      txAck   <= strb.loadByte;
      done    <= strb.finish;
    end
  end

  // R2: never more than one line pulled low
  assert_single_line_R2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(busOe));
  // R9: each capture acknowledged by a single-cycle pulse
  assert_ack_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    txAck |=> !txAck);
endmodule

// File: rtl/owBusMaster.sv
module owBusMaster
  import owPkg::*;
#(
  parameter int NUM_BUS          = 8,
  parameter int DATA_W           = 8,
  parameter int CNT_W            = 8,
  parameter int CFG_W            = 8,
  parameter int RESET_LOW_TICKS  = 96,
  parameter int RESET_HIGH_TICKS = 96,
  parameter int PRESENCE_DELAY   = 14,
  localparam int SEL_W = $clog2(NUM_BUS)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               startReq,
  input  logic               cmdReset,
  input  logic               cmdRead,
  input  logic [SEL_W-1:0]   busSel,
  input  logic [CNT_W-1:0]   byteCount,
  input  logic [DATA_W-1:0]  txData,
  output logic               txAck,
  output logic [DATA_W-1:0]  rxData,
  output logic               rxValid,
  input  logic [CFG_W-1:0]   cfgLowTicks,
  input  logic [CFG_W-1:0]   cfgSampleTicks,
  input  logic [CFG_W-1:0]   cfgSlotTicks,
  input  logic [CFG_W-1:0]   cfgRecoverTicks,
  input  logic [NUM_BUS-1:0] busIn,
  output logic [NUM_BUS-1:0] busOe,
  output logic               busy,
  output logic               done,
  output logic               presence
);
  owStrobes_t strb;

  owCtl #(
    .NUM_BUS(NUM_BUS), .DATA_W(DATA_W), .CNT_W(CNT_W), .CFG_W(CFG_W),
    .RESET_LOW_TICKS(RESET_LOW_TICKS), .RESET_HIGH_TICKS(RESET_HIGH_TICKS),
    .PRESENCE_DELAY(PRESENCE_DELAY)
  ) ctl_i (
    .clk(clk), .rstN(rstN), .startReq(startReq), .cmdReset(cmdReset),
    .cmdRead(cmdRead), .busSel(busSel), .byteCount(byteCount), .busIn(busIn),
    .cfgLowTicks(cfgLowTicks), .cfgSampleTicks(cfgSampleTicks),
    .cfgSlotTicks(cfgSlotTicks), .cfgRecoverTicks(cfgRecoverTicks),
    .busy(busy), .strb(strb)
  );

  owDp #(.NUM_BUS(NUM_BUS), .DATA_W(DATA_W)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .busSel(busSel), .txData(txData),
    .busIn(busIn), .busOe(busOe), .presence(presence), .rxData(rxData),
    .rxValid(rxValid), .txAck(txAck), .done(done)
  );

  // R2: all lines released whenever no command runs
  assert_idle_released_R2: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (busOe == '0));
  // R11: the datapath never latches a new command while busy
  assert_no_start_while_busy_R11: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !strb.loadCfg);
  // R10: done only right after busy falls
  assert_done_after_busy_R10: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!busy && $past(busy)));
endmodule

// File: tb/owBusMaster_tb.sv
module owBusMaster_tb_top;
  localparam int RL = 64, RH = 64, PD = 20;
  localparam int LOW_T = 4, SAMP_T = 10, SLOT_T = 24, REC_T = 4;
  localparam int WD_LIMIT = 150000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startReq = 1'b0, cmdReset = 1'b0, cmdRead = 1'b0;
  logic [2:0] busSel = '0;
  logic [7:0] byteCount = '0;
  logic [7:0] txData;
  logic txAck, rxValid, busy, done, presence;
  logic [7:0] rxData;
  logic [7:0] busIn, busOe;
  logic [7:0] slaveLow = '0, plugLow = '0;

  always #2.5 clk = ~clk;

  logic [7:0] txMem [0:255];
  int txIdx = 0;
  assign txData = txMem[txIdx[7:0]];
  assign busIn  = ~(busOe | slaveLow | plugLow);

  owBusMaster #(.RESET_LOW_TICKS(RL), .RESET_HIGH_TICKS(RH), .PRESENCE_DELAY(PD)) dut_i (
    .clk(clk), .rstN(rstN), .startReq(startReq), .cmdReset(cmdReset), .cmdRead(cmdRead),
    .busSel(busSel), .byteCount(byteCount), .txData(txData), .txAck(txAck),
    .rxData(rxData), .rxValid(rxValid), .cfgLowTicks(8'(LOW_T)), .cfgSampleTicks(8'(SAMP_T)),
    .cfgSlotTicks(8'(SLOT_T)), .cfgRecoverTicks(8'(REC_T)), .busIn(busIn), .busOe(busOe),
    .busy(busy), .done(done), .presence(presence)
  );

  // slave devices: presence answer after a long low, read-zero hold per slot
  logic [7:0] devPresent = '0;
  logic       rdOn = 1'b0;
  int         rdBus = 0;
  logic [15:0] readPat = '0;
  int sRun [8], sPres [8], sHold [8];
  logic [7:0] sPrev = '0;
  int rdPtr = 0;
  initial for (int b = 0; b < 8; b++) begin sRun[b] = 0; sPres[b] = 0; sHold[b] = 0; end

  always @(posedge clk) begin
    if (!rdOn) rdPtr = 0;
    for (int b = 0; b < 8; b++) begin
      if (sPrev[b] && !busOe[b] && sRun[b] >= RL && devPresent[b]) sPres[b] = 1;
      if (busOe[b]) sRun[b]++; else sRun[b] = 0;
      if (!sPrev[b] && busOe[b] && rdOn && rdBus == b) begin
        if (!readPat[rdPtr[3:0]]) sHold[b] = 16;
        rdPtr++;
      end
      if (sPres[b] > 0) sPres[b]++;
      if (sPres[b] > 45) sPres[b] = 0;
      slaveLow[b] <= (sPres[b] >= 6) || (sHold[b] > 0);
      if (sHold[b] > 0) sHold[b]--;
    end
    sPrev = busOe;
  end

  // behavioural reference, updated on each rising edge
  int mState, mT, mBit, mLeft, mSel, mTx, mRx;
  bit mRead, mPres, mDone, mRxV, mAck;
  always @(posedge clk) begin
    if (!rstN) begin
      mState = 0; mT = 0; mBit = 0; mLeft = 0; mSel = 0; mTx = 0; mRx = 0;
      mRead = 0; mPres = 0; mDone = 0; mRxV = 0; mAck = 0;
    end else begin
      mDone = 0; mRxV = 0; mAck = 0;
      case (mState)
        0: begin
          if (!busIn[busSel]) mPres = 1;
          if (startReq) begin
            if (cmdReset) begin mState = 1; mT = 0; mSel = busSel; mPres = 0; end
            else if (byteCount != 0) begin
              mState = 2; mT = 0; mBit = 0; mLeft = byteCount; mRead = cmdRead; mSel = busSel;
              if (!cmdRead) begin mTx = txData; mAck = 1; end
            end
          end
        end
        1: begin
          if (mT == RL + PD) mPres = !busIn[mSel];
          if (mT == RL + RH - 1) begin mState = 0; mDone = 1; end else mT++;
        end
        default: begin
          if (mRead && mT == SAMP_T) mRx = (mRx >> 1) | (int'(busIn[mSel]) << 7);
          if (mT == SLOT_T + REC_T - 1) begin
            mT = 0;
            if (mBit == 7) begin
              mBit = 0;
              if (mRead) mRxV = 1;
              if (mLeft == 1) begin mState = 0; mDone = 1; end
              else begin mLeft--; if (!mRead) begin mTx = txData; mAck = 1; end end
            end else begin mBit++; mTx = mTx >> 1; end
          end else mT++;
        end
      endcase
    end
  end

  function automatic int expOe();
    if (mState == 1 && mT < RL) return 1 << mSel;
    if (mState == 2 && (mT < LOW_T || (!mRead && (mTx & 1) == 0 && mT < SLOT_T))) return 1 << mSel;
    return 0;
  endfunction

  int total = 0, bad = 0, cyc = 0;
  int busyCyc, doneCnt, ackCnt, run, wrBus;
  int oeCyc [8];
  bit wrQ [$];
  logic [7:0] rxQ [$];

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    cyc++;
    if (cyc > WD_LIMIT) begin
      chk("watchdog", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
    if (rstN) begin
      chk("R2 R7 busOe vs model", busOe, expOe());
      chk("R10 busy vs model", busy, mState != 0);
      chk("R10 done vs model", done, mDone);
      chk("R4 R5 presence vs model", presence, mPres);
      chk("R8 rxValid vs model", rxValid, mRxV);
      if (rxValid) chk("R8 rxData vs model", rxData, mRx);
      chk("R9 txAck vs model", txAck, mAck);
    end
    if (txAck) begin txIdx++; ackCnt++; end
    if (busy) busyCyc++;
    if (done) doneCnt++;
    if (rxValid) rxQ.push_back(rxData);
    for (int b = 0; b < 8; b++) oeCyc[b] += int'(busOe[b]);
    if (busOe[wrBus]) run++;
    else if (run > 0) begin wrQ.push_back(run <= LOW_T); run = 0; end
  endtask

  task automatic kick(bit r, bit rd, int sel, int cnt);
    busyCyc = 0; doneCnt = 0; ackCnt = 0; run = 0; wrBus = sel; txIdx = 0;
    for (int b = 0; b < 8; b++) oeCyc[b] = 0;
    wrQ.delete(); rxQ.delete();
    cmdReset = r; cmdRead = rd; busSel = 3'(sel); byteCount = 8'(cnt); startReq = 1'b1;
    step();
    startReq = 1'b0;
  endtask

  task automatic waitDone();
    while (!done) step();
  endtask

  function automatic int wrByte(int k);
    int v = 0;
    for (int i = 0; i < 8; i++) if (wrQ[k * 8 + i]) v |= (1 << i);
    return v;
  endfunction

  initial begin
    for (int i = 0; i < 256; i++) txMem[i] = 8'((i * 37 + 11) & 255);
    wrBus = 0; run = 0;
    repeat (5) step();
    rstN = 1'b1;
    step();
    // R1 reset state
    chk("R1 busy", busy, 0); chk("R1 done", done, 0); chk("R1 busOe", busOe, 0);
    chk("R1 presence", presence, 0); chk("R1 rxValid", rxValid, 0); chk("R1 txAck", txAck, 0);

    // R3 R4 reset with a device on line 3
    devPresent[3] = 1'b1;
    kick(1, 0, 3, 0); waitDone();
    chk("R3 low cycles", oeCyc[3], RL);
    chk("R3 busy cycles", busyCyc, RL + RH);
    chk("R2 other lines", oeCyc[0] + oeCyc[5], 0);
    chk("R4 presence seen", presence, 1);
    chk("R10 single done", doneCnt, 1);
    step(); chk("R10 done one cycle", done, 0);

    // R4 reset on empty line 5
    kick(1, 0, 5, 0); waitDone();
    chk("R4 no presence", presence, 0);

    // R5 hot plug: other line ignored, watched line sets the flag
    plugLow[0] = 1'b1; repeat (3) step(); plugLow[0] = 1'b0; step();
    chk("R5 other line ignored", presence, 0);
    plugLow[5] = 1'b1; repeat (3) step(); plugLow[5] = 1'b0; step();
    chk("R5 watched line sets", presence, 1);

    // R7 R9 write three bytes on line 2
    txMem[0] = 8'hA5; txMem[1] = 8'h3C; txMem[2] = 8'hFF;
    kick(0, 0, 2, 3); waitDone();
    chk("R7 bit count", wrQ.size(), 24);
    if (wrQ.size() == 24) begin
      chk("R7 byte0", wrByte(0), 8'hA5);
      chk("R7 byte1", wrByte(1), 8'h3C);
      chk("R7 byte2", wrByte(2), 8'hFF);
    end
    chk("R9 acks", ackCnt, 3);
    chk("R10 write busy cycles", busyCyc, 3 * 8 * (SLOT_T + REC_T));

    // R8 read two bytes from line 6
    rdBus = 6; readPat = 16'h815A; rdOn = 1'b1;
    kick(0, 1, 6, 2); waitDone();
    rdOn = 1'b0;
    chk("R8 byte count", rxQ.size(), 2);
    if (rxQ.size() == 2) begin
      chk("R8 byte0", rxQ[0], 8'h5A);
      chk("R8 byte1", rxQ[1], 8'h81);
    end
    chk("R9 no ack on read", ackCnt, 0);

    // R6 zero count ignored
    kick(0, 0, 2, 0); repeat (6) step();
    chk("R6 zero count busy", busyCyc, 0);
    chk("R6 zero count done", doneCnt, 0);

    // R11 start while busy
    txMem[0] = 8'h0F;
    kick(0, 0, 1, 1);
    repeat (20) step();
    cmdReset = 1'b1; busSel = 3'd4; startReq = 1'b1; step(); startReq = 1'b0;
    waitDone();
    repeat (5) step();
    chk("R11 line 4 untouched", oeCyc[4], 0);
    chk("R11 one done", doneCnt, 1);
    chk("R11 idle after", busy, 0);
    if (wrQ.size() == 8) chk("R11 byte kept", wrByte(0), 8'h0F);
    else chk("R11 bit count", wrQ.size(), 8);

    // R6 R9 full 255-byte burst
    for (int i = 0; i < 256; i++) txMem[i] = 8'((i * 37 + 11) & 255);
    kick(0, 0, 7, 255); waitDone();
    chk("R6 R9 burst acks", ackCnt, 255);
    begin
      int miss = 0;
      if (wrQ.size() != 255 * 8) miss = 1;
      else for (int k = 0; k < 255; k++) if (wrByte(k) != ((k * 37 + 11) & 255)) miss++;
      chk("R6 R7 burst data mismatches", miss, 0);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule